// File: doc/BRIEF.md
# Latched Five-Digit Decade Event Counter

This block counts rising edges of an external pulse input with five decade (BCD) stages that carry and borrow into one another. It counts up or down and can be paused with an enable line. The live count is not shown directly. A display register holds the last transferred reading, so the visible digits stay steady while a new measurement builds up. An active-low latch strobe copies the live count into that register. Each held digit drives a seven-segment pattern.

A sticky flag sets whenever the count wraps past 99999 going up, or below 00000 going down. A controlling unit, such as a gate-time or prescaler sequencer, uses it to pick a coarser range. A typical measurement cycle has three steps: count during the gate, strobe the latch, then pulse reset. The reset clears the live count and the flag and leaves the displayed reading in place.

Top module: `decade_event_counter`

## Requirements
- R1: Each rising edge of `cnt_in` adds exactly one step to the live count. The input passes through a two-flop synchronizer, so the step lands on the third rising clock edge after `cnt_in` rises.
- R2: With `dir_up` = 1 a step increments the live count, and with `dir_up` = 0 it decrements it.
- R3: While `cnt_en` = 0, edges on `cnt_in` leave the live count unchanged.
- R4: Each digit holds a BCD value from 0 to 9. Digit i sits at `disp_bcd[4i+3:4i]`, and digit 0 is the least significant. Stepping up from 9 gives 0 and advances the next digit. Stepping down from 0 gives 9 and retreats the next digit.
- R5: Stepping up from 99999 gives 00000, and stepping down from 00000 gives 99999. Either wrap sets `ovf_flag`. The flag then stays at 1 through later counting and wraps until reset.
- R6: A falling edge on `latch_n`, synchronized like `cnt_in`, copies the live count into the display register on the third clock edge after the fall. At all other times `disp_bcd` holds its value.
- R7: If a count step and a latch event fall on the same clock edge, the display receives the count from before that step.
- R8: A synchronous high `rst` clears all digits of the live count and `ovf_flag`. It does not change `disp_bcd`.
- R9: `seg_o[7i+6:7i]` is the pattern for displayed digit i, with bit 0 = segment a up to bit 6 = segment g. The values for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high clear of count and flag |
| cnt_in | input | 1 | Asynchronous pulse input being counted |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| cnt_en | input | 1 | 1 = accept count edges |
| latch_n | input | 1 | Active-low transfer strobe |
| seg_o | output | 35 | Seven-segment patterns, 7 bits per digit |
| disp_bcd | output | 20 | Held BCD digits, 4 bits per digit |
| ovf_flag | output | 1 | Sticky wrap indicator |

## Verification
The bench drives counts through several carry and borrow chains. A stage that mishandled its terminal value would show a wrong digit such as 0000A, or would fail to carry into the next digit. It reaches 99999 with one down step from zero and then wraps back up. A wrong wrap or a flag that cleared itself would show up here as a wrong reading or as the flag dropping. It strobes the latch on the same edge as a count. A display that took the new count would read one higher than expected. It also pulses reset while 99999 is shown, which catches a design that wipes the display or leaves the flag set.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int DIG_W = 4;
  localparam int SEG_W = 7;

  // next value of one decade stage in the chosen direction
  function automatic logic [3:0] dec_next(input logic [3:0] d, input logic up);
    if (up) dec_next = (d == 4'd9) ? 4'd0 : d + 4'd1;
    else    dec_next = (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction

  // segment map, bit0 = a .. bit6 = g
  function automatic logic [6:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0: seg_of = 7'h3F;
      4'd1: seg_of = 7'h06;
      4'd2: seg_of = 7'h5B;
      4'd3: seg_of = 7'h4F;
      4'd4: seg_of = 7'h66;
      4'd5: seg_of = 7'h6D;
      4'd6: seg_of = 7'h7D;
      4'd7: seg_of = 7'h07;
      4'd8: seg_of = 7'h7F;
      4'd9: seg_of = 7'h6F;
      default: seg_of = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/cnt_sync_edge.sv
module cnt_sync_edge #(
  parameter logic IDLE    = 1'b0,
  parameter bit   FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {3{IDLE}};
    else     sh <= {sh[1:0], din};
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = ~sh[1] & sh[2];
    end else begin : g_rise
      assign edge_o = sh[1] & ~sh[2];
    end
  endgenerate

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o); // R1
endmodule

// File: rtl/decade_stage.sv
module decade_stage
  import dcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             up_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             term_o
);
  logic [DIG_W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst)         d_q <= '0;
    else if (step_i) d_q <= dec_next(d_q, up_i);
  end

  assign digit_o = d_q;
  assign term_o  = up_i ? (d_q == 4'd9) : (d_q == 4'd0);

  AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (rst)
    d_q <= 4'd9); // R4
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_i && up_i && d_q == 4'd9) |=> d_q == 4'd0); // R4
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_i && !up_i && d_q == 4'd0) |=> d_q == 4'd9); // R4
endmodule

// File: rtl/decade_event_counter.sv
module decade_event_counter
  import dcnt_pkg::*;
#(
  parameter int NDIG = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_in,
  input  logic                  dir_up,
  input  logic                  cnt_en,
  input  logic                  latch_n,
  output logic [NDIG*SEG_W-1:0] seg_o,
  output logic [NDIG*DIG_W-1:0] disp_bcd,
  output logic                  ovf_flag
);
  localparam int BW = NDIG * DIG_W;

  logic          cnt_rise;
  logic          latch_evt;
  logic          step;
  logic          wrap;
  logic [NDIG:0] chain;
  logic [NDIG-1:0] term;
  logic [BW-1:0] live;
  logic [BW-1:0] disp_q;
  logic          ovf_q;

  cnt_sync_edge #(.IDLE(1'b0), .FALLING(1'b0)) u_cnt_sync (
    .clk(clk), .rst(rst), .din(cnt_in), .edge_o(cnt_rise));

  cnt_sync_edge #(.IDLE(1'b1), .FALLING(1'b1)) u_lat_sync (
    .clk(clk), .rst(rst), .din(latch_n), .edge_o(latch_evt));

  assign step     = cnt_rise & cnt_en;
  assign chain[0] = step;

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      decade_stage u_stage (
        .clk(clk), .rst(rst), .step_i(chain[i]), .up_i(dir_up),
        .digit_o(live[i*DIG_W +: DIG_W]), .term_o(term[i]));
      assign chain[i+1] = chain[i] & term[i];
    end
  endgenerate

  assign wrap = chain[NDIG];

  always_ff @(posedge clk) begin
    if (rst)       ovf_q <= 1'b0;
    else if (wrap) ovf_q <= 1'b1;
  end

  // display register intentionally survives rst
  always_ff @(posedge clk) begin
    if (latch_evt) disp_q <= live;
  end

  generate
    for (genvar j = 0; j < NDIG; j++) begin : g_seg
      assign seg_o[j*SEG_W +: SEG_W] = seg_of(disp_q[j*DIG_W +: DIG_W]);
    end
  endgenerate

  assign disp_bcd = disp_q;
  assign ovf_flag = ovf_q;

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(live)); // R3
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(wrap)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q); // R5
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_evt |=> $stable(disp_q)); // R6
  AST_LATCH_OLD: assert property (@(posedge clk) disable iff (rst)
    latch_evt |=> disp_q == $past(live)); // R7
endmodule

// File: tb/sim_decade_event_counter.sv
`timescale 1ns/1ps
module sim_decade_event_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_in = 1'b0;
  logic dir_up = 1'b1;
  logic cnt_en = 1'b1;
  logic latch_n = 1'b1;
  logic [34:0] seg_o;
  logic [19:0] disp_bcd;
  logic ovf_flag;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  decade_event_counter u0 (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .dir_up(dir_up), .cnt_en(cnt_en),
    .latch_n(latch_n), .seg_o(seg_o), .disp_bcd(disp_bcd), .ovf_flag(ovf_flag));

  localparam logic [6:0] SEGTAB [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                         7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  // {dir, en, edges[7:0], expected BCD[19:0]}
  localparam logic [29:0] VEC [6] = '{
    {1'b1, 1'b1, 8'd7,   20'h00007},
    {1'b1, 1'b1, 8'd5,   20'h00012},
    {1'b0, 1'b1, 8'd3,   20'h00009},
    {1'b1, 1'b0, 8'd4,   20'h00009},
    {1'b1, 1'b1, 8'd95,  20'h00104},
    {1'b0, 1'b1, 8'd104, 20'h00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_segs(input string req);
    for (int k = 0; k < 5; k++) begin
      logic [3:0] d;
      d = disp_bcd[k*4 +: 4];
      chk(req, {25'd0, seg_o[k*7 +: 7]}, (d < 10) ? {25'd0, SEGTAB[d]} : 32'hFFFF_FFFF);
    end
  endtask

  task automatic pulse_cnt;
    @(negedge clk) cnt_in = 1'b1;
    repeat (2) @(negedge clk);
    cnt_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_latch;
    @(negedge clk) latch_n = 1'b0;
    repeat (2) @(negedge clk);
    latch_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // reset state
    chk("R8 flag after reset", {31'd0, ovf_flag}, 32'd0);
    do_latch();
    chk("R8 count after reset", {12'd0, disp_bcd}, 32'h00000);
    chk_segs("R9 zero pattern");

    // vector table
    for (int v = 0; v < 6; v++) begin
      dir_up = VEC[v][29];
      cnt_en = VEC[v][28];
      for (int p = 0; p < int'(VEC[v][27:20]); p++) pulse_cnt();
      do_latch();
      chk("R1 R2 R3 R4 vector count", {12'd0, disp_bcd}, {12'd0, VEC[v][19:0]});
      chk("R5 no flag in range", {31'd0, ovf_flag}, 32'd0);
      chk_segs("R9 vector pattern");
    end
    cnt_en = 1'b1;

    // R6: display holds without latch
    dir_up = 1'b1;
    for (int p = 0; p < 3; p++) pulse_cnt();
    chk("R6 display held", {12'd0, disp_bcd}, 32'h00000);
    do_latch();
    chk("R6 display after latch", {12'd0, disp_bcd}, 32'h00003);

    // R7: coincident count and latch
    @(negedge clk) begin cnt_in = 1'b1; latch_n = 1'b0; end
    repeat (2) @(negedge clk);
    cnt_in = 1'b0; latch_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 latched pre-step value", {12'd0, disp_bcd}, 32'h00003);
    do_latch();
    chk("R7 step still applied", {12'd0, disp_bcd}, 32'h00004);

    // R5: underflow and overflow
    do_reset();
    dir_up = 1'b0;
    pulse_cnt();
    chk("R5 flag on underflow", {31'd0, ovf_flag}, 32'd1);
    do_latch();
    chk("R5 underflow wraps to 99999", {12'd0, disp_bcd}, 32'h99999);
    chk_segs("R9 nine pattern");
    dir_up = 1'b1;
    pulse_cnt();
    do_latch();
    chk("R5 overflow wraps to 00000", {12'd0, disp_bcd}, 32'h00000);
    chk("R5 flag sticky after second wrap", {31'd0, ovf_flag}, 32'd1);
    pulse_cnt();
    chk("R5 flag sticky while counting", {31'd0, ovf_flag}, 32'd1);

    // R8: reset keeps display, clears flag and count
    dir_up = 1'b0;
    pulse_cnt();
    pulse_cnt();
    do_latch();
    chk("R4 borrow to 99999", {12'd0, disp_bcd}, 32'h99999);
    do_reset();
    chk("R8 flag cleared", {31'd0, ovf_flag}, 32'd0);
    chk("R8 display retained", {12'd0, disp_bcd}, 32'h99999);
    do_latch();
    chk("R8 count cleared", {12'd0, disp_bcd}, 32'h00000);

    finish_run();
  end
endmodule